// File: doc/BRIEF.md
# Retention Test Flow Sequencer

This block steers a short production flow that checks whether a low-power SRAM keeps its contents in deep sleep. It runs an external sleep-aware March engine three times. Each run uses one pairing of tester supply level and regulator reference select, so the regulated array voltage lands just above the worst-case retention level of about 730 mV. Sweeping every pairing would take twelve runs.

For each run the sequencer holds a supply-level request until the tester acknowledges it. It then pulses a start to the March engine and waits for the engine's completion. The engine reports when the array is in deep sleep. The sequencer grants the wake-up only after a minimum dwell, which defaults to 1 ms at 250 MHz. The result of each run is kept in a fail vector, and an overall pass and a done flag close the flow. A configuration bit, taken when the flow starts, decides whether the flow stops at the first failing run.

Top module: `rts_flow_seq`

## Requirements
- R1: After reset, done_o, pass_o, busy_o, supply_req_o, march_start_o and wake_ok_o are 0 and fail_vec_o is all zero.
- R2: The runs use these pairs in this order: run 0 (supply_lvl_o=0, 1.0 V; vref_sel_o=01, 0.74 of VDD), run 1 (1, 1.1 V; 10, 0.70), run 2 (2, 1.2 V; 11, 0.64). Select code 00 means 0.78 of VDD.
- R3: supply_req_o stays high, with supply_lvl_o stable, until supply_ack_i is sampled high. In the next cycle march_start_o is high for exactly one cycle and supply_req_o is low.
- R4: When march_done_i is sampled in run i, bit i of fail_vec_o becomes the inverse of march_pass_i.
- R5: With stop_on_fail_i high at start, the flow ends after the first failing run, issues no further supply request, and leaves the bits of the skipped runs at 0.
- R6: With stop_on_fail_i low at start, all three runs execute whatever their results.
- R7: pass_o is high exactly when done_o is high and no run failed.
- R8: done_o rises in the cycle after the engine completes the last executed run, and stays high until the next start. start_i has no effect while busy_o is high.
- R9: While a run is active, wake_ok_o rises only after ds_active_i has been high for DWELL_CYCLES consecutive cycles. A drop of ds_active_i restarts the count.
- R10: Accepting a start clears fail_vec_o and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a flow (when idle or done) |
| stop_on_fail_i | input | 1 | End the flow at the first failing run |
| supply_req_o | output | 1 | Supply level request to the tester |
| supply_lvl_o | output | 2 | Requested supply: 0=1.0 V, 1=1.1 V, 2=1.2 V |
| supply_ack_i | input | 1 | Tester reports that the supply is settled |
| vref_sel_o | output | 2 | Regulator reference select |
| march_start_o | output | 1 | One-cycle start to the March engine |
| march_done_i | input | 1 | Engine completion pulse |
| march_pass_i | input | 1 | Engine result, valid with march_done_i |
| ds_active_i | input | 1 | Engine holds the array in deep sleep |
| wake_ok_o | output | 1 | Minimum sleep dwell has elapsed |
| busy_o | output | 1 | Flow in progress |
| done_o | output | 1 | Flow finished |
| pass_o | output | 1 | All runs passed |
| fail_vec_o | output | 3 | Per-run fail bits, bit 0 = first run |

## Verification
The bench builds the block with DWELL_CYCLES set to 20 instead of the 1 ms default. With that value the exact cycle at which wake_ok_o rises can be counted in every run, including a case where the dwell is interrupted and must restart. A short dwell also lets many full three-run flows, in both stop modes and with failures in each position, fit into one short run. The counter width is derived from DWELL_CYCLES, so the smaller value exercises the same saturation and restart logic as the default.

// File: rtl/rts_pkg.sv
package rts_pkg;
  localparam int unsigned NUM_ITER = 3;
  localparam int unsigned ITER_W   = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_SUPPLY, S_LAUNCH, S_RUN, S_FIN
  } seq_state_e;

  // supply code per run: 0=1.0V, 1=1.1V, 2=1.2V
  function automatic logic [1:0] iter_lvl(input logic [ITER_W-1:0] idx);
    return 2'(idx);
  endfunction

  // reference code per run: 01=0.74, 10=0.70, 11=0.64
  function automatic logic [1:0] iter_sel(input logic [ITER_W-1:0] idx);
    return 2'(idx) + 2'd1;
  endfunction
endpackage

// File: rtl/rts_dwell_timer.sv
module rts_dwell_timer #(
  parameter int unsigned DWELL_CYCLES = 250000,
  localparam int unsigned CNT_W = $clog2(DWELL_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ds_i,
  output logic wake_ok_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sleeping;

  assign sleeping = en_i && ds_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (!sleeping)                       cnt_q <= '0;
    else if (cnt_q != CNT_W'(DWELL_CYCLES))   cnt_q <= cnt_q + 1'b1;
  end

  assign wake_ok_o = sleeping && (cnt_q == CNT_W'(DWELL_CYCLES));

  p_wake_after_sleep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_ok_o) |-> ($past(ds_i) && $past(en_i)));
  p_cnt_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleeping |=> (cnt_q == '0));
endmodule

// File: rtl/rts_result_log.sv
module rts_result_log
  import rts_pkg::*;
#(
  parameter int unsigned N = NUM_ITER
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rec_i,
  input  logic [ITER_W-1:0] idx_i,
  input  logic              fail_i,
  output logic [N-1:0]      fail_vec_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    fail_vec_o[g] <= 1'b0;
      else if (clr_i)                                 fail_vec_o[g] <= 1'b0;
      else if (rec_i && (idx_i == ITER_W'(g)))        fail_vec_o[g] <= fail_i;
    end
  end

  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (fail_vec_o == '0));
  p_one_bit_per_rec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !rec_i) |=> $stable(fail_vec_o));
endmodule

// File: rtl/rts_flow_seq.sv
module rts_flow_seq
  import rts_pkg::*;
#(
  parameter int unsigned DWELL_CYCLES = 250000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_on_fail_i,
  output logic                supply_req_o,
  output logic [1:0]          supply_lvl_o,
  input  logic                supply_ack_i,
  output logic [1:0]          vref_sel_o,
  output logic                march_start_o,
  input  logic                march_done_i,
  input  logic                march_pass_i,
  input  logic                ds_active_i,
  output logic                wake_ok_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o,
  output logic [NUM_ITER-1:0] fail_vec_o
);
  localparam logic [ITER_W-1:0] LAST_IDX = ITER_W'(NUM_ITER - 1);

  seq_state_e        state_q, state_d;
  logic [ITER_W-1:0] idx_q, idx_d;
  logic              stop_q;
  logic              accept, record, finish;

  assign accept = ((state_q == S_IDLE) || (state_q == S_FIN)) && start_i;
  assign record = (state_q == S_RUN) && march_done_i;
  assign finish = record && ((idx_q == LAST_IDX) || (stop_q && !march_pass_i));

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      S_IDLE, S_FIN: if (start_i) begin
        state_d = S_SUPPLY;
        idx_d   = '0;
      end
      S_SUPPLY: if (supply_ack_i) state_d = S_LAUNCH;
      S_LAUNCH: state_d = S_RUN;
      S_RUN: if (march_done_i) begin
        if (finish) state_d = S_FIN;
        else begin
          state_d = S_SUPPLY;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      stop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (accept) stop_q <= stop_on_fail_i;
    end
  end

  assign supply_req_o  = (state_q == S_SUPPLY);
  assign march_start_o = (state_q == S_LAUNCH);
  assign supply_lvl_o  = iter_lvl(idx_q);
  assign vref_sel_o    = iter_sel(idx_q);
  assign busy_o        = (state_q != S_IDLE) && (state_q != S_FIN);
  assign done_o        = (state_q == S_FIN);
  assign pass_o        = done_o && (fail_vec_o == '0);

  rts_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_dwell (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (state_q == S_RUN),
    .ds_i      (ds_active_i),
    .wake_ok_o (wake_ok_o)
  );

  rts_result_log #(.N(NUM_ITER)) u_log (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .rec_i      (record),
    .idx_i      (idx_q),
    .fail_i     (!march_pass_i),
    .fail_vec_o (fail_vec_o)
  );

  p_req_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_req_o && !supply_ack_i) |=> (supply_req_o && $stable(supply_lvl_o)));
  p_start_after_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(march_start_o) |-> $past(supply_ack_i));
  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    march_start_o |=> !march_start_o);
  p_done_after_engine_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(march_done_i));
  p_done_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  p_pass_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (done_o && (fail_vec_o == '0)));
  p_sel_within_run_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (march_start_o || (busy_o && !supply_req_o)) |-> (vref_sel_o != 2'b00));
endmodule

// File: tb/tb_rts_flow_seq.sv
module tb_rts_flow_seq;
  localparam int DWELL = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop_cfg = 0, ack = 0, mdone = 0, mpass = 0, ds = 0;
  logic req, mstart, wake, busy, done, pass;
  logic [1:0] lvl, sel;
  logic [2:0] fvec;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rts_flow_seq #(.DWELL_CYCLES(DWELL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_on_fail_i(stop_cfg),
    .supply_req_o(req), .supply_lvl_o(lvl), .supply_ack_i(ack),
    .vref_sel_o(sel), .march_start_o(mstart), .march_done_i(mdone),
    .march_pass_i(mpass), .ds_active_i(ds), .wake_ok_o(wake),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fail_vec_o(fvec));

  // {stop, pass pattern (bit i = run i), exp fail vec, exp runs, exp pass}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 3'b111, 3'b000, 2'd3, 1'b1},
    {1'b0, 3'b101, 3'b010, 2'd3, 1'b0},
    {1'b1, 3'b101, 3'b010, 2'd2, 1'b0},
    {1'b1, 3'b110, 3'b001, 2'd1, 1'b0},
    {1'b0, 3'b000, 3'b111, 2'd3, 1'b0},
    {1'b1, 3'b011, 3'b100, 2'd3, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_flow(input bit stp, input logic [2:0] pat, input int runs,
                          input logic [2:0] exp_fv, input bit exp_pass,
                          input bit poke_start, input bit poke_dwell);
    bit early;
    stop_cfg = stp;
    start = 1;
    @(negedge clk);
    start = 0;
    stop_cfg = ~stp;  // must be ignored: latched at start
    chk(!done && fvec == 3'b000, "R10 clear on start", int'(fvec), 0);
    for (int i = 0; i < 3; i++) begin
      if (i >= runs) begin
        repeat (3) @(negedge clk);
        chk(!req && done, "R5 no further request", int'(req), 0);
        break;
      end
      for (int t = 0; t < 50 && !req; t++) @(negedge clk);
      chk(req && lvl == 2'(i) && sel == 2'(i + 1), "R2 pair order",
          int'({lvl, sel}), int'({2'(i), 2'(i + 1)}));
      repeat (2) @(negedge clk);
      chk(req && lvl == 2'(i) && !mstart, "R3 request held", int'(req), 1);
      ack = 1;
      @(negedge clk);
      ack = 0;
      chk(mstart && !req, "R3 start after ack", int'(mstart), 1);
      @(negedge clk);
      chk(!mstart, "R3 one-cycle start", int'(mstart), 0);
      if (poke_start && i == 1) begin
        start = 1;
        @(negedge clk);
        start = 0;
        chk(busy && lvl == 2'd1 && !req, "R8 start ignored while busy", int'(lvl), 1);
      end
      if (poke_dwell && i == 0) begin
        early = 0;
        ds = 1;
        for (int k = 0; k < DWELL - 1; k++) begin
          if (wake) early = 1;
          @(negedge clk);
        end
        ds = 0;
        @(negedge clk);
        chk(!early && !wake, "R9 interrupted dwell", int'(wake), 0);
      end
      early = 0;
      ds = 1;
      for (int k = 0; k < DWELL; k++) begin
        if (wake) early = 1;
        @(negedge clk);
      end
      chk(!early && wake, "R9 dwell length", int'(wake), 1);
      ds = 0;
      mpass = pat[i];
      mdone = 1;
      @(negedge clk);
      mdone = 0;
      chk(fvec[i] == ~pat[i], "R4 fail bit", int'(fvec[i]), int'(~pat[i]));
    end
    chk(done && !busy, "R8 done after last run", int'(done), 1);
    chk(fvec == exp_fv, stp ? "R5 fail vector stop mode" : "R6 fail vector full run",
        int'(fvec), int'(exp_fv));
    chk(pass == exp_pass, "R7 aggregate pass", int'(pass), int'(exp_pass));
    repeat (4) @(negedge clk);
    chk(done && fvec == exp_fv, "R8 done held", int'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(!done && !pass && !busy && !req && !mstart && !wake && fvec == 0,
        "R1 reset state", int'({done, pass, busy, req, mstart, wake}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !req, "R1 idle after reset", int'(busy), 0);
    foreach (VEC[v]) begin
      run_flow(VEC[v][9], VEC[v][8:6], int'(VEC[v][2:1]), VEC[v][5:3], VEC[v][0], 0, 0);
    end
    // directed: start pulse while busy, and a broken dwell
    run_flow(0, 3'b111, 3, 3'b000, 1, 1, 1);
    // R10: restart after a failing flow clears the results
    run_flow(1, 3'b110, 1, 3'b001, 0, 0, 0);
    run_flow(0, 3'b111, 3, 3'b000, 1, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule